// File: doc/BRIEF.md
# Grouped Interrupt Priority Arbiter

This block chooses which exception should be taken next. It watches a set of external interrupt lines and three fixed-priority system sources. Each external line has a pending flag, an enable and a 4-bit priority, which is written through a simple write port. Out of all eligible sources it picks one winner and reports that winner's exception number. It then checks whether the winner may interrupt the code that is running now.

A 3-bit grouping selector moves a split point inside the 4-bit priority. The upper part is the group, which is the only part that can pre-empt. The lower part is the subpriority, which only orders pending sources against each other. When two lines have the same priority value, the line number breaks the tie. The current execution level comes in on its own port, either as a settable level 0..15 or as a fixed level -3..-1. A separate flag says that nothing is active.

The result is held in a three-state register:
- `ARB_IDLE`: no source is eligible.
- `ARB_HOLD`: a winner exists but does not pre-empt.
- `ARB_PREEMPT`: a winner exists and pre-empts.

On every clock the next state is chosen from the inputs, so every state can be reached from every other state. The transition into `ARB_IDLE` happens when no source is eligible. The transition into `ARB_HOLD` happens on a non-pre-empting winner, and the transition into `ARB_PREEMPT` happens on a pre-empting winner.

Top module: `gprio_arbiter`

## Requirements
- R1: During reset and in the first cycle after it, `win_valid`, `preempt_req` and `win_exc` are 0. All line priorities reset to 0.
- R2: Fixed sources win over every external line, whether that line is enabled or not. `fix_pend[0]` is reported as exception 1 (level -3), `fix_pend[1]` as exception 2 (level -2) and `fix_pend[2]` as exception 3 (level -1). The lower level wins.
- R3: An external line is eligible only when it is both pending and enabled. With no eligible source, `win_valid` is 0 and the state is `ARB_IDLE`.
- R4: Among eligible lines, the lowest numeric priority wins. Line n is reported as exception 16+n.
- R5: Among eligible lines with identical priority values, the lower line index wins.
- R6: The grouping selector sets the number of group bits, counted from the priority MSB. Values 0 to 3 give 4 group bits, 4 gives 3, 5 gives 2, 6 gives 1 and 7 gives 0. The remaining low bits are the subpriority.
- R7: `preempt_req` is 1 only when the winner's group value is strictly less than the group value of the current level. Subpriority bits play no part in this comparison.
- R8: When `cur_valid` is 0, any winner pre-empts.
- R9: A fixed current level (-3..-1) is compared as a number. No external line can pre-empt it. A fixed source pre-empts it only with a strictly lower level.
- R10: Outputs are registered. They follow the inputs sampled at the previous rising edge. A priority write takes effect in the arbitration at the edge after the write.
- R11: A write with `prio_we` high stores `prio_wdata` as the priority of line `prio_wsel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pend | input | NUM_LINES | Pending flag per external line |
| irq_en | input | NUM_LINES | Enable per external line |
| fix_pend | input | 3 | Pending fixed sources (levels -3, -2, -1) |
| grp_sel | input | 3 | Group/subpriority split selector |
| prio_we | input | 1 | Priority write strobe |
| prio_wsel | input | IDX_W | Line index to write |
| prio_wdata | input | 4 | Priority value to write |
| cur_valid | input | 1 | An exception level is currently active |
| cur_pri | input | 5 | Signed current level, -3..15 |
| win_valid | output | 1 | A winner exists |
| win_exc | output | EXC_W | Winner exception number |
| preempt_req | output | 1 | Winner pre-empts the current level |

## Verification
The hardest case to reach is the one where two sources share a group but differ in subpriority, and the current level sits in that same group. The winner must then be reported without a pre-empt request. The stimulus reaches this case in directed steps. It programs matching group bits under several grouping selections and places `cur_pri` just inside and just outside the winner's group. Random rounds then mix priority writes, enable masks, fixed sources and signed current levels. Each round is compared against a bench model of the grouping rule.

// File: rtl/gprio_pkg.sv
package gprio_pkg;
    localparam int PRIO_W = 4;
    localparam int FIX_N  = 3;

    typedef enum logic [1:0] {
        ARB_IDLE    = 2'd0,
        ARB_HOLD    = 2'd1,
        ARB_PREEMPT = 2'd2
    } arb_state_e;

    // Mask that keeps the group bits of a priority value
    function automatic logic [PRIO_W-1:0] group_mask(input logic [2:0] sel);
        int gbits;
        gbits = (sel < 3'd3) ? PRIO_W : (7 - int'(sel));
        return ~(PRIO_W'({PRIO_W{1'b1}}) >> gbits);
    endfunction
endpackage

// File: rtl/gprio_regs.sv
module gprio_regs
    import gprio_pkg::*;
#(
    parameter int NUM_LINES = 8,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                we,
    input  logic [IDX_W-1:0]                    wsel,
    input  logic [PRIO_W-1:0]                   wdata,
    output logic [NUM_LINES-1:0][PRIO_W-1:0]    prio_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prio_q <= '0;
        end else if (we && (int'(wsel) < NUM_LINES)) begin
            prio_q[wsel] <= wdata;
        end
    end

    // R11
    prio_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (int'(wsel) < NUM_LINES)) |=> (prio_q[$past(wsel)] == $past(wdata)));
endmodule

// File: rtl/gprio_pick.sv
module gprio_pick
    import gprio_pkg::*;
#(
    parameter int NUM_LINES = 8,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic [NUM_LINES-1:0]                pend,
    input  logic [NUM_LINES-1:0]                en,
    input  logic [NUM_LINES-1:0][PRIO_W-1:0]    prio,
    output logic                                any,
    output logic [IDX_W-1:0]                    idx,
    output logic [PRIO_W-1:0]                   best
);
    always_comb begin
        any  = 1'b0;
        idx  = '0;
        best = '1;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (pend[i] && en[i] && (!any || (prio[i] < best))) begin
                any  = 1'b1;
                idx  = IDX_W'(i);
                best = prio[i];
            end
        end
    end
endmodule

// File: rtl/gprio_cmp.sv
module gprio_cmp
    import gprio_pkg::*;
(
    input  logic [2:0]         grp_sel,
    input  logic               win_fixed,
    input  logic signed [5:0]  win_fix_lvl,
    input  logic [PRIO_W-1:0]  win_prio,
    input  logic               cur_valid,
    input  logic signed [4:0]  cur_pri,
    output logic               preempt
);
    logic [PRIO_W-1:0]  mask;
    logic signed [5:0]  win_grp;
    logic signed [5:0]  cur_grp;

    always_comb begin
        mask = group_mask(grp_sel);
        if (win_fixed) begin
            win_grp = win_fix_lvl;
        end else begin
            win_grp = $signed({2'b00, win_prio & mask});
        end
        if (!cur_valid) begin
            cur_grp = 6'sd16;
        end else if (cur_pri[4]) begin
            cur_grp = {cur_pri[4], cur_pri};
        end else begin
            cur_grp = $signed({2'b00, cur_pri[3:0] & mask});
        end
        preempt = (win_grp < cur_grp);
    end
endmodule

// File: rtl/gprio_arbiter.sv
module gprio_arbiter
    import gprio_pkg::*;
#(
    parameter int NUM_LINES = 8,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    localparam int EXC_W = $clog2(16 + NUM_LINES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_LINES-1:0]    irq_pend,
    input  logic [NUM_LINES-1:0]    irq_en,
    input  logic [FIX_N-1:0]        fix_pend,
    input  logic [2:0]              grp_sel,
    input  logic                    prio_we,
    input  logic [IDX_W-1:0]        prio_wsel,
    input  logic [PRIO_W-1:0]       prio_wdata,
    input  logic                    cur_valid,
    input  logic signed [4:0]       cur_pri,
    output logic                    win_valid,
    output logic [EXC_W-1:0]        win_exc,
    output logic                    preempt_req
);
    logic [NUM_LINES-1:0][PRIO_W-1:0] prio_q;
    logic                  line_any;
    logic [IDX_W-1:0]      line_idx;
    logic [PRIO_W-1:0]     line_best;
    logic                  fix_any;
    logic signed [5:0]     fix_lvl;
    logic [EXC_W-1:0]      nxt_exc;
    logic                  cmp_pre;
    arb_state_e            state_q, state_d;
    logic [EXC_W-1:0]      exc_q;

    gprio_regs #(.NUM_LINES(NUM_LINES)) i_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (prio_we),
        .wsel   (prio_wsel),
        .wdata  (prio_wdata),
        .prio_q (prio_q)
    );

    gprio_pick #(.NUM_LINES(NUM_LINES)) i_pick (
        .pend (irq_pend),
        .en   (irq_en),
        .prio (prio_q),
        .any  (line_any),
        .idx  (line_idx),
        .best (line_best)
    );

    // Fixed sources: index 0 is the most urgent
    always_comb begin
        fix_any = |fix_pend;
        fix_lvl = -6'sd1;
        nxt_exc = '0;
        if (fix_pend[0]) begin
            fix_lvl = -6'sd3;
            nxt_exc = EXC_W'(1);
        end else if (fix_pend[1]) begin
            fix_lvl = -6'sd2;
            nxt_exc = EXC_W'(2);
        end else if (fix_pend[2]) begin
            fix_lvl = -6'sd1;
            nxt_exc = EXC_W'(3);
        end else if (line_any) begin
            nxt_exc = EXC_W'(16 + int'(line_idx));
        end
    end

    gprio_cmp i_cmp (
        .grp_sel     (grp_sel),
        .win_fixed   (fix_any),
        .win_fix_lvl (fix_lvl),
        .win_prio    (line_best),
        .cur_valid   (cur_valid),
        .cur_pri     (cur_pri),
        .preempt     (cmp_pre)
    );

    // Next-state selection
    always_comb begin
        if (!(fix_any || line_any)) begin
            state_d = ARB_IDLE;
        end else if (cmp_pre) begin
            state_d = ARB_PREEMPT;
        end else begin
            state_d = ARB_HOLD;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            exc_q   <= '0;
        end else begin
            state_q <= state_d;
            exc_q   <= (state_d == ARB_IDLE) ? '0 : nxt_exc;
        end
    end

    // Outputs
    always_comb begin
        win_valid   = 1'b0;
        preempt_req = 1'b0;
        win_exc     = exc_q;
        unique case (state_q)
            ARB_IDLE:    win_exc = '0;
            ARB_HOLD:    win_valid = 1'b1;
            ARB_PREEMPT: begin
                win_valid   = 1'b1;
                preempt_req = 1'b1;
            end
            default:     win_exc = '0;
        endcase
    end

    // R2
    fixed_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fix_pend[0] |=> (win_valid && win_exc == EXC_W'(1)));

    // R3
    idle_when_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|(irq_pend & irq_en)) && !(|fix_pend)) |=> (!win_valid && !preempt_req));

    // R6
    no_group_no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_sel == 3'd7 && cur_valid && !cur_pri[4] && !(|fix_pend)) |=> !preempt_req);

    // R8
    idle_level_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur_valid && ((|(irq_pend & irq_en)) || (|fix_pend))) |=> preempt_req);

    // R9
    fixed_level_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_valid && cur_pri[4] && !(|fix_pend)) |=> !preempt_req);

    // R4
    exc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> ((win_exc >= EXC_W'(1) && win_exc <= EXC_W'(3)) ||
                       (int'(win_exc) >= 16 && int'(win_exc) < 16 + NUM_LINES)));
endmodule

// File: tb/test_gprio_arbiter.sv
module test_gprio_arbiter;
    localparam int N     = 8;
    localparam int IDX_W = $clog2(N);
    localparam int EXC_W = $clog2(16 + N);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] irq_pend = '0, irq_en = '0;
    logic [2:0] fix_pend = '0, grp_sel = '0;
    logic prio_we = 1'b0;
    logic [IDX_W-1:0] prio_wsel = '0;
    logic [3:0] prio_wdata = '0;
    logic cur_valid = 1'b0;
    logic signed [4:0] cur_pri = '0;
    logic win_valid, preempt_req;
    logic [EXC_W-1:0] win_exc;

    int checks = 0, fails = 0;
    logic [3:0] mprio [N];

    always #5 clk = ~clk;

    gprio_arbiter #(.NUM_LINES(N)) i_gprio_arbiter (
        .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .irq_en(irq_en),
        .fix_pend(fix_pend), .grp_sel(grp_sel), .prio_we(prio_we),
        .prio_wsel(prio_wsel), .prio_wdata(prio_wdata), .cur_valid(cur_valid),
        .cur_pri(cur_pri), .win_valid(win_valid), .win_exc(win_exc),
        .preempt_req(preempt_req));

    function automatic int gbits_of(input logic [2:0] s);
        case (s)
            3'd4: return 3;
            3'd5: return 2;
            3'd6: return 1;
            3'd7: return 0;
            default: return 4;
        endcase
    endfunction

    function automatic int grp_of(input int p, input logic [2:0] s);
        int sh;
        sh = 4 - gbits_of(s);
        return (p >> sh) << sh;
    endfunction

    // Expected {valid, exc, preempt}
    task automatic model(output logic ev, output int ee, output logic ep);
        int wg, cg, best, bi;
        ev = 1'b0; ee = 0; ep = 1'b0; wg = 0;
        best = 99; bi = -1;
        for (int i = 0; i < N; i++)
            if (irq_pend[i] && irq_en[i] && int'(mprio[i]) < best) begin
                best = int'(mprio[i]); bi = i;
            end
        if (fix_pend[0])      begin ev = 1; ee = 1; wg = -3; end
        else if (fix_pend[1]) begin ev = 1; ee = 2; wg = -2; end
        else if (fix_pend[2]) begin ev = 1; ee = 3; wg = -1; end
        else if (bi >= 0)     begin ev = 1; ee = 16 + bi; wg = grp_of(best, grp_sel); end
        if (!cur_valid) cg = 16;
        else if (cur_pri < 0) cg = int'(cur_pri);
        else cg = grp_of(int'(cur_pri), grp_sel);
        ep = ev && (wg < cg);
    endtask

    task automatic chk(input string tag);
        logic ev, ep; int ee;
        model(ev, ee, ep);
        @(posedge clk); @(negedge clk);
        checks++;
        if (win_valid !== ev || int'(win_exc) != ee || preempt_req !== ep) begin
            fails++;
            $display("FAIL %s: got valid=%0b exc=%0d pre=%0b, expected valid=%0b exc=%0d pre=%0b",
                     tag, win_valid, win_exc, preempt_req, ev, ee, ep);
        end
    endtask

    task automatic wr(input int line, input int val);
        prio_we = 1'b1; prio_wsel = IDX_W'(line); prio_wdata = 4'(val);
        @(posedge clk); @(negedge clk);
        prio_we = 1'b0;
        mprio[line] = 4'(val);
    endtask

    initial begin
        #1_000_000;
        checks++; fails++;
        $display("FAIL watchdog: got no finish, expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < N; i++) mprio[i] = 4'd0;
        repeat (3) @(negedge clk);
        checks++;
        if (win_valid !== 1'b0 || preempt_req !== 1'b0 || win_exc !== '0) begin
            fails++;
            $display("FAIL R1: got %0b/%0d/%0b expected 0/0/0", win_valid, win_exc, preempt_req);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (win_valid !== 1'b0 || preempt_req !== 1'b0 || win_exc !== '0) begin
            fails++;
            $display("FAIL R1: got %0b/%0d/%0b expected 0/0/0", win_valid, win_exc, preempt_req);
        end
        // R1: all priorities zero, so equal ties fall to the lowest enabled line
        irq_pend = 8'hF0; irq_en = 8'hFF; chk("R1");
        // R3: pending but disabled
        irq_pend = 8'hFF; irq_en = 8'h00; chk("R3");
        irq_pend = 8'h0F; irq_en = 8'hF0; chk("R3");
        // R11 / R4 / R5 / R8
        for (int i = 0; i < N; i++) wr(i, 12);
        wr(2, 5); wr(5, 3); wr(6, 3);
        irq_pend = 8'hFF; irq_en = 8'hFF; cur_valid = 0; chk("R4");
        irq_pend = 8'h64; chk("R5");
        irq_pend = 8'h44; chk("R11");
        // R2
        fix_pend = 3'b110; irq_en = 8'h00; chk("R2");
        fix_pend = 3'b111; chk("R2");
        fix_pend = 3'b100; chk("R2");
        fix_pend = 3'b000; irq_en = 8'hFF; irq_pend = 8'h60;
        // R7 with 2.2 split: winner 3 in group 0
        grp_sel = 3'd5; cur_valid = 1; cur_pri = 5'sd2; chk("R7");
        cur_pri = 5'sd4; chk("R7");
        cur_pri = 5'sd3; chk("R7");
        // R6 variants
        grp_sel = 3'd7; cur_pri = 5'sd15; chk("R6");
        grp_sel = 3'd0; cur_pri = 5'sd4; chk("R6");
        grp_sel = 3'd4; cur_pri = 5'sd2; chk("R6");
        grp_sel = 3'd6; cur_pri = 5'sd8; chk("R6");
        grp_sel = 3'd6; cur_pri = 5'sd7; chk("R6");
        // R9: fixed current level
        grp_sel = 3'd3; cur_pri = -5'sd1; wr(5, 0); chk("R9");
        fix_pend = 3'b100; chk("R9");
        fix_pend = 3'b010; chk("R9");
        fix_pend = 3'b000; cur_pri = -5'sd3; chk("R9");
        // R10: a write changes the winner on the following edge
        cur_valid = 0; irq_pend = 8'h60; wr(5, 9); chk("R10");
        // Random rounds
        for (int k = 0; k < 400; k++) begin
            if ($urandom_range(3, 0) == 0) wr(int'($urandom_range(N - 1, 0)), int'($urandom_range(15, 0)));
            irq_pend  = N'($urandom);
            irq_en    = N'($urandom);
            fix_pend  = ($urandom_range(5, 0) == 0) ? 3'($urandom) : 3'b000;
            grp_sel   = 3'($urandom);
            cur_valid = 1'($urandom);
            cur_pri   = 5'(int'($urandom_range(18, 0)) - 3);
            if (fix_pend != 0) chk("R2");
            else if ((irq_pend & irq_en) == 0) chk("R3");
            else chk("R7");
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule